// File: doc/BRIEF.md
# Nonvolatile Shadow Transfer Guard

This block controls how data moves between a small volatile word array and the nonvolatile array that shadows it bit for bit. A store copies the volatile array into the nonvolatile one. A recall copies the other way. Requests come from two sources: a one-cycle software command strobe, and two active-low hardware pins, one for store and one for recall.

Two protection flags decide what is allowed. One is a write-enable flag. The other is a flag that records that a deliberate recall has taken place since power-up. A store is accepted only when both flags are set. Volatile writes from the host are also gated by both flags.

A power-on reset stands in for supply sensing. It clears both flags and starts an automatic recall, so the volatile array again holds the last stored image. That recall does not count as a deliberate one. Store and recall each last a configurable number of clock cycles. The block is busy for that time and rejects everything else. The copy itself happens in a single cycle at the end.

Top module: `nvx_store_ctrl`

## Requirements
- R1: While `por` is high, `wen_state` and `rcl_state` are 0 and `busy` is 1.
- R2: After `por` falls, an automatic recall keeps `busy` high for exactly RCL_CYCLES cycles and then loads every volatile word from the nonvolatile array. It leaves `rcl_state` at 0, and commands issued during it have no effect.
- R3: A software recall (`cmd_op` = 2'b11) keeps `busy` high for RCL_CYCLES cycles, copies the nonvolatile array into the volatile one, and sets `rcl_state`.
- R4: A falling edge on `recall_n`, seen through a synchronizer, has the same effect as a software recall.
- R5: A store request (software `cmd_op` = 2'b01, or a falling edge on `store_n`) is dropped unless both `wen_state` and `rcl_state` are 1. When it is dropped, `busy` stays 0.
- R6: An accepted store keeps `busy` high for STO_CYCLES cycles, copies the volatile array into the nonvolatile one, and clears `wen_state` when it finishes. The stored image survives a later `por`.
- R7: While `busy` is 1, commands, pin edges and host writes are all ignored, and no second transfer starts.
- R8: `cmd_op` = 2'b10 sets `wen_state` and `cmd_op` = 2'b00 clears it. `wr_ok` equals `wen_state & rcl_state & ~busy`. A host write changes the array only when `wr_ok` is 1.
- R9: A pin edge that arrives in a cycle where `cmd_valid` is 1 is discarded.
- R10: If both pins fall in the same cycle, the recall is performed and the store is dropped, so `wen_state` is unchanged.
- R11: A pin held low causes only one transfer, and releasing the pin starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Software command strobe, one cycle per command |
| cmd_op | input | 2 | Command code: 00 write-disable, 01 store, 10 write-enable, 11 recall |
| store_n | input | 1 | Asynchronous active-low hardware store request |
| recall_n | input | 1 | Asynchronous active-low hardware recall request |
| ram_wr_en | input | 1 | Host volatile write strobe |
| ram_wr_addr | input | AW | Host write word address |
| ram_wr_data | input | WIDTH | Host write data |
| ram_rd_addr | input | AW | Host read word address |
| ram_rd_data | output | WIDTH | Registered read data |
| busy | output | 1 | A transfer is in progress |
| wr_ok | output | 1 | Host writes are currently permitted |
| wen_state | output | 1 | Write-enable flag |
| rcl_state | output | 1 | Deliberate-recall flag |

## Verification
Transfers are started in four ways: by software strobe, by a pin falling, by a pin held low, and by both pins falling together. Each busy window is counted to the exact cycle. This separates a correct transfer from a lost one or a repeated one. Store requests are tried with neither flag, one flag and both flags set, which shows that both guards are enforced. Words written while access is locked or the block is busy, a recall that overwrites a changed word, and a power cycle that brings back a stored image each show which array received which copy, and when.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [1:0] {
    OP_WEN_CLR = 2'b00,
    OP_STORE   = 2'b01,
    OP_WEN_SET = 2'b10,
    OP_RECALL  = 2'b11
  } nvx_op_e;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_PU_RCL = 2'd1,
    XS_RECALL = 2'd2,
    XS_STORE  = 2'd3
  } nvx_xstate_e;
endpackage

// File: rtl/nvx_pin_edge.sv
module nvx_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n_i,
  output logic fall_o
);
  // sh_q[SYNC_STAGES-1] is the synchronized level; sh_q[SYNC_STAGES] is its previous value
  logic [SYNC_STAGES:0] sh_q;
  logic                 fall_q;

  always_ff @(posedge clk) begin
    if (por) begin
      sh_q   <= '1;
      fall_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC_STAGES-1:0], pin_n_i};
      fall_q <= sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = fall_q;

  // R11: a level held low produces a single one-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (por)
    fall_q |=> !fall_q);
endmodule

// File: rtl/nvx_xfer_seq.sv
module nvx_xfer_seq
  import nvx_pkg::*;
#(
  parameter int STO_CYCLES = 50000,
  parameter int RCL_CYCLES = 20
) (
  input  logic       clk,
  input  logic       por,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       hw_store_fall,
  input  logic       hw_recall_fall,
  input  logic       we_i,
  input  logic       rcl_i,
  output logic       busy_o,
  output logic       wen_set_o,
  output logic       wen_clr_o,
  output logic       store_done_o,
  output logic       recall_done_o,
  output logic       pu_done_o
);
  localparam int MAXC = (STO_CYCLES > RCL_CYCLES) ? STO_CYCLES : RCL_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  nvx_xstate_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          idle, sw_rcl, sw_sto, hw_ok, rcl_req, sto_req;

  assign idle    = (state_q == XS_IDLE);
  assign sw_rcl  = cmd_valid && (nvx_op_e'(cmd_op) == OP_RECALL);
  assign sw_sto  = cmd_valid && (nvx_op_e'(cmd_op) == OP_STORE);
  assign hw_ok   = !cmd_valid;
  assign rcl_req = idle && (sw_rcl || (hw_ok && hw_recall_fall));
  assign sto_req = idle && !rcl_req && we_i && rcl_i &&
                   (sw_sto || (hw_ok && hw_store_fall));

  assign wen_set_o = idle && cmd_valid && (nvx_op_e'(cmd_op) == OP_WEN_SET);
  assign wen_clr_o = idle && cmd_valid && (nvx_op_e'(cmd_op) == OP_WEN_CLR);

  assign store_done_o  = (state_q == XS_STORE)  && (cnt_q == '0);
  assign recall_done_o = (state_q == XS_RECALL) && (cnt_q == '0);
  assign pu_done_o     = (state_q == XS_PU_RCL) && (cnt_q == '0);
  assign busy_o        = !idle;

  always_ff @(posedge clk) begin
    if (por) begin
      state_q <= XS_PU_RCL;
      cnt_q   <= CW'(RCL_CYCLES - 1);
    end else if (idle) begin
      if (rcl_req) begin
        state_q <= XS_RECALL;
        cnt_q   <= CW'(RCL_CYCLES - 1);
      end else if (sto_req) begin
        state_q <= XS_STORE;
        cnt_q   <= CW'(STO_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      state_q <= XS_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: entry into a store only with both guards set one cycle earlier
  a_r5_store_guarded: assert property (@(posedge clk) disable iff (por)
    (state_q == XS_STORE && $past(state_q) == XS_IDLE) |-> $past(we_i && rcl_i));
  // R7: an unfinished transfer keeps its kind
  a_r7_no_preempt: assert property (@(posedge clk) disable iff (por)
    (!idle && cnt_q != '0) |=> (state_q == $past(state_q)));
  // R2: the automatic recall is only ever entered from reset
  a_r2_pu_from_reset: assert property (@(posedge clk) disable iff (por)
    (state_q == XS_PU_RCL) |-> ($past(state_q) == XS_PU_RCL));
endmodule

// File: rtl/nvx_guard_latches.sv
module nvx_guard_latches (
  input  logic clk,
  input  logic por,
  input  logic wen_set_i,
  input  logic wen_clr_i,
  input  logic store_done_i,
  input  logic recall_done_i,
  input  logic busy_i,
  output logic we_o,
  output logic rcl_o,
  output logic wr_ok_o
);
  logic we_q, rcl_q;

  always_ff @(posedge clk) begin
    if (por) begin
      we_q  <= 1'b0;
      rcl_q <= 1'b0;
    end else begin
      if (store_done_i)   we_q <= 1'b0;
      else if (wen_set_i) we_q <= 1'b1;
      else if (wen_clr_i) we_q <= 1'b0;
      if (recall_done_i)  rcl_q <= 1'b1;
    end
  end

  assign we_o    = we_q;
  assign rcl_o   = rcl_q;
  assign wr_ok_o = we_q & rcl_q & ~busy_i;

  // R6: a finished store leaves writes disabled
  a_r6_store_drops_wen: assert property (@(posedge clk) disable iff (por)
    store_done_i |=> !we_q);
  // R8: enable command takes effect on the next cycle
  a_r8_wen_set: assert property (@(posedge clk) disable iff (por)
    wen_set_i |=> we_q);
  // R3: a deliberate recall leaves the recall flag set
  a_r3_rcl_sets: assert property (@(posedge clk) disable iff (por)
    recall_done_i |=> rcl_q);
endmodule

// File: rtl/nvx_store_ctrl.sv
module nvx_store_ctrl
  import nvx_pkg::*;
#(
  parameter int WORDS       = 16,
  parameter int WIDTH       = 16,
  parameter int STO_CYCLES  = 50000,
  parameter int RCL_CYCLES  = 20,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORDS*WIDTH-1:0] NV_INIT = '0,
  localparam int AW   = $clog2(WORDS),
  localparam int BITS = WORDS * WIDTH
) (
  input  logic             clk,
  input  logic             por,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             store_n,
  input  logic             recall_n,
  input  logic             ram_wr_en,
  input  logic [AW-1:0]    ram_wr_addr,
  input  logic [WIDTH-1:0] ram_wr_data,
  input  logic [AW-1:0]    ram_rd_addr,
  output logic [WIDTH-1:0] ram_rd_data,
  output logic             busy,
  output logic             wr_ok,
  output logic             wen_state,
  output logic             rcl_state
);
  localparam int NPINS = 2;  // index 0 = store, 1 = recall

  logic [NPINS-1:0] pin_n, pin_fall;
  logic wen_set, wen_clr, store_done, recall_done, pu_done;

  assign pin_n = {recall_n, store_n};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    nvx_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .por     (por),
      .pin_n_i (pin_n[g]),
      .fall_o  (pin_fall[g])
    );
  end

  nvx_xfer_seq #(.STO_CYCLES(STO_CYCLES), .RCL_CYCLES(RCL_CYCLES)) u_seq (
    .clk            (clk),
    .por            (por),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .hw_store_fall  (pin_fall[0]),
    .hw_recall_fall (pin_fall[1]),
    .we_i           (wen_state),
    .rcl_i          (rcl_state),
    .busy_o         (busy),
    .wen_set_o      (wen_set),
    .wen_clr_o      (wen_clr),
    .store_done_o   (store_done),
    .recall_done_o  (recall_done),
    .pu_done_o      (pu_done)
  );

  nvx_guard_latches u_guard (
    .clk           (clk),
    .por           (por),
    .wen_set_i     (wen_set),
    .wen_clr_i     (wen_clr),
    .store_done_i  (store_done),
    .recall_done_i (recall_done),
    .busy_i        (busy),
    .we_o          (wen_state),
    .rcl_o         (rcl_state),
    .wr_ok_o       (wr_ok)
  );

  // Flat images so each transfer is a single-cycle bulk copy; nv_q is not reset
  logic [BITS-1:0] ram_q = '0;
  logic [BITS-1:0] nv_q  = NV_INIT;

  always_ff @(posedge clk) begin
    if (recall_done || pu_done)
      ram_q <= nv_q;
    else if (ram_wr_en && wr_ok)
      ram_q[ram_wr_addr*WIDTH +: WIDTH] <= ram_wr_data;
  end

  always_ff @(posedge clk) begin
    if (store_done) nv_q <= ram_q;
  end

  always_ff @(posedge clk) begin
    ram_rd_data <= ram_q[ram_rd_addr*WIDTH +: WIDTH];
  end

  // R8: a refused write leaves the volatile image untouched
  a_r8_locked_write: assert property (@(posedge clk) disable iff (por)
    (ram_wr_en && !wr_ok && !recall_done && !pu_done) |=> $stable(ram_q));
  // R5: nonvolatile image changes only through a completed store
  a_r5_nv_only_by_store: assert property (@(posedge clk) disable iff (por)
    !store_done |=> $stable(nv_q));
  // R2: automatic recall never sets the recall flag
  a_r2_pu_keeps_flag: assert property (@(posedge clk) disable iff (por)
    (pu_done && !rcl_state) |=> !rcl_state);
endmodule

// File: tb/nvx_store_ctrl_tb.sv
module nvx_store_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 16;
  localparam int WIDTH = 16;
  localparam int STO = 12;
  localparam int RCL = 5;
  localparam int WIN = STO + 12;
  localparam logic [255:0] NV_PAT =
    256'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_1111_2222_3333_4444_5555_6666_7777_8888;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic store_n = 1'b1, recall_n = 1'b1;
  logic ram_wr_en = 1'b0;
  logic [3:0] ram_wr_addr = '0, ram_rd_addr = '0;
  logic [15:0] ram_wr_data = '0;
  logic [15:0] ram_rd_data;
  logic busy, wr_ok, wen_state, rcl_state;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvx_store_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH), .STO_CYCLES(STO), .RCL_CYCLES(RCL),
                   .SYNC_STAGES(2), .NV_INIT(NV_PAT)) dut_i (
    .clk(clk), .por(por), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .store_n(store_n), .recall_n(recall_n), .ram_wr_en(ram_wr_en),
    .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_rd_data), .busy(busy), .wr_ok(wr_ok),
    .wen_state(wen_state), .rcl_state(rcl_state));

  function automatic logic [15:0] nv0(input int i);
    return NV_PAT[i*16 +: 16];
  endfunction
  function automatic logic [15:0] fillw(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); ram_wr_en = 1'b1; ram_wr_addr = 4'(a); ram_wr_data = d;
    @(negedge clk); ram_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); ram_rd_addr = 4'(a);
    @(negedge clk); d = ram_rd_data;
  endtask

  // counts busy cycles over a window starting at the current negedge
  task automatic busy_win(output int n);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic power_up(input bit with_cmd, output int n);
    @(negedge clk); por = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 wen during por", wen_state, 0);
    chk("R1 rcl during por", rcl_state, 0);
    chk("R1 busy during por", busy, 1);
    por = 1'b0;
    if (with_cmd) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      if (busy) n++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic t_powerup();
    int n; logic [15:0] d;
    power_up(1'b1, n);
    chk("R2 pu busy length", n, RCL);
    chk("R2 cmd ignored during pu", wen_state, 0);
    chk("R2 pu leaves rcl clear", rcl_state, 0);
    rd(0, d);  chk("R2 word0", d, nv0(0));
    rd(7, d);  chk("R2 word7", d, nv0(7));
    rd(15, d); chk("R2 word15", d, nv0(15));
  endtask

  task automatic t_write_locked();
    logic [15:0] d;
    chk("R8 wr_ok low after pu", wr_ok, 0);
    wr(1, 16'hAAAA);
    rd(1, d); chk("R8 locked write ignored", d, nv0(1));
  endtask

  task automatic t_store_locked();
    int n;
    issue(2'b10);
    chk("R8 wen set", wen_state, 1);
    issue(2'b01); busy_win(n);
    chk("R5 store refused without rcl", n, 0);
    issue(2'b00);
    chk("R8 wen cleared", wen_state, 0);
    issue(2'b01); busy_win(n);
    chk("R5 store refused without flags", n, 0);
  endtask

  task automatic t_sw_recall();
    int n;
    issue(2'b11); busy_win(n);
    chk("R3 recall busy length", n, RCL);
    chk("R3 rcl set", rcl_state, 1);
    issue(2'b01); busy_win(n);
    chk("R5 store refused without wen", n, 0);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    issue(2'b10);
    chk("R8 wr_ok with both flags", wr_ok, 1);
    for (int i = 0; i < WORDS; i++) wr(i, fillw(i));
    rd(0, d);  chk("R8 fill word0", d, fillw(0));
    rd(9, d);  chk("R8 fill word9", d, fillw(9));
  endtask

  task automatic t_sw_store();
    int n;
    issue(2'b01); busy_win(n);
    chk("R6 store busy length", n, STO);
    chk("R6 store clears wen", wen_state, 0);
    chk("R8 wr_ok low after store", wr_ok, 0);
  endtask

  task automatic t_busy_ignore();
    int n; logic [15:0] d;
    issue(2'b10);
    issue(2'b01);
    chk("R7 busy during store", busy, 1);
    ram_wr_en = 1'b1; ram_wr_addr = 4'd4; ram_wr_data = 16'hFFFF; store_n = 1'b0;
    @(negedge clk); ram_wr_en = 1'b0;
    repeat (STO + 4) @(negedge clk);
    busy_win(n);
    chk("R7 no second store", n, 0);
    store_n = 1'b1;
    rd(4, d); chk("R7 write during busy ignored", d, fillw(4));
  endtask

  task automatic t_power_cycle();
    int n; logic [15:0] d;
    power_up(1'b0, n);
    chk("R2 pu busy length again", n, RCL);
    rd(4, d);  chk("R6 stored word4 survives", d, fillw(4));
    rd(12, d); chk("R6 stored word12 survives", d, fillw(12));
    chk("R2 rcl clear after cycle", rcl_state, 0);
  endtask

  task automatic t_hw_recall();
    int n; logic [15:0] d;
    issue(2'b11); busy_win(n);
    issue(2'b10);
    wr(3, 16'hDEAD);
    rd(3, d); chk("R8 word3 changed", d, 16'hDEAD);
    recall_n = 1'b0; busy_win(n);
    chk("R4 pin recall busy length", n, RCL);
    rd(3, d); chk("R4 pin recall restores word3", d, fillw(3));
    busy_win(n);
    chk("R11 held pin no repeat", n, 0);
    recall_n = 1'b1; busy_win(n);
    chk("R11 release no action", n, 0);
  endtask

  task automatic t_hw_store();
    int n; logic [15:0] d;
    wr(5, 16'hBEEF);
    store_n = 1'b0; busy_win(n);
    chk("R6 pin store busy length", n, STO);
    chk("R6 pin store clears wen", wen_state, 0);
    store_n = 1'b1; busy_win(n);
    issue(2'b10);
    wr(5, 16'h1234);
    issue(2'b11); busy_win(n);
    rd(5, d); chk("R6 pin store reached nv", d, 16'hBEEF);
  endtask

  task automatic t_cmd_blocks_hw();
    int n; logic [15:0] d;
    wr(2, 16'h7777);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10;
      if (i == 1) recall_n = 1'b0;
      if (busy) n++;
    end
    @(negedge clk); cmd_valid = 1'b0;
    busy_win(n);
    chk("R9 pin edge under command dropped", n, 0);
    rd(2, d); chk("R9 word2 kept", d, 16'h7777);
    recall_n = 1'b1; busy_win(n);
  endtask

  task automatic t_both_pins();
    int n; logic [15:0] d;
    chk("R10 wen before", wen_state, 1);
    store_n = 1'b0; recall_n = 1'b0; busy_win(n);
    chk("R10 recall wins busy length", n, RCL);
    chk("R10 wen untouched", wen_state, 1);
    rd(2, d); chk("R10 recall applied", d, fillw(2));
    store_n = 1'b1; recall_n = 1'b1; busy_win(n);
  endtask

  initial begin
    t_powerup();
    t_write_locked();
    t_store_locked();
    t_sw_recall();
    t_fill();
    t_sw_store();
    t_busy_ignore();
    t_power_cycle();
    t_hw_recall();
    t_hw_store();
    t_cmd_blocks_hw();
    t_both_pins();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule